// File: doc/BRIEF.md
# Dual-Edge Transition Capture Sampler

This block times when a slow digital signal changes within one cycle of a slower phase clock. It samples the signal under test on both the rising and the falling edge of a fast master clock. Each edge feeds its own shift register, so the pair together hold a sampling window at twice the master-clock rate. With a 16 MHz master clock and a 1 MHz phase clock, the window spans about one phase cycle at roughly 30 ns per sample.

The phase clock is brought into the master-clock domain through a flop synchronizer. On its detected rising edge, the block freezes the merged, time-ordered window into a holding register. It also stores a transition map, in which each bit is the XOR of two neighbouring samples. A set bit marks the interval in which the signal changed level, and a cycle with no change gives an all-zero map.

Results leave through a plain one-cycle strobe with no back-pressure. The consumer must take the data in the strobe cycle or read it later from the held outputs, which stay unchanged until the next accepted snapshot.

Top module: `dts_transition_sampler`

## Requirements
- R1: While `rst_n` is low, `snap_o`, `edge_map_o` and `valid_o` are all zero.
- R2: A snapshot holds W = 2*HALF_DEPTH samples spaced half a master period apart, with bit 0 the oldest. Even bit 2k is a falling-edge sample and odd bit 2k+1 is the rising-edge sample that follows it. Bit W-1 is the signal's value at the master rising edge that takes the snapshot.
- R3: With SYNC_STAGES=2, a rise of `phi_i` set up before master rising edge P0 is captured at rising edge P2, two edges later. `valid_o` is high in the cycle that follows P2.
- R4: `edge_map_o` has W-1 bits, and bit i equals snapshot bit i XOR snapshot bit i+1. Its count of ones is therefore odd exactly when snapshot bits 0 and W-1 differ.
- R5: When every sample in the window has the same level, `edge_map_o` is all zero.
- R6: `valid_o` is a single-cycle pulse, given once for each accepted rise of `phi_i`.
- R7: Between strobes, `snap_o` and `edge_map_o` hold their values.
- R8: A snapshot is accepted only when at least HALF_DEPTH master rising edges have occurred between reset release and the capture edge. An earlier rise of `phi_i` gives no strobe and leaves the outputs unchanged.
- R9: A falling edge of `phi_i` takes no snapshot and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sampling clock; both edges sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi_i | input | 1 | Asynchronous phase clock of the measured device |
| probe_i | input | 1 | Asynchronous signal under test |
| snap_o | output | 2*HALF_DEPTH | Held sample window, oldest sample at bit 0 |
| edge_map_o | output | 2*HALF_DEPTH-1 | XOR map of adjacent samples |
| valid_o | output | 1 | One-cycle strobe for a new snapshot |

## Verification
The bench builds the block with the defaults, HALF_DEPTH=16 and SYNC_STAGES=2. This gives a 32-sample window and a 31-bit map, so the bench can compare the full window of every snapshot bit by bit against its own record of the signal at each clock edge. Because only sixteen edges are needed to fill the window, the bench can place phase rises just below and exactly at the fill boundary after a reset. The fixed two-edge capture delay lets it pin every strobe to a single cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic {
    FILLING = 1'b0,
    ARMED   = 1'b1
  } fill_state_e;
endpackage

// File: rtl/dts_phase_sync.sv
module dts_phase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], phase_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dts_shift_bank.sv
module dts_shift_bank #(
  parameter int DEPTH   = 16,
  parameter bit ON_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] q,
  output logic [DEPTH-1:0] q_next
);
  // newest sample enters at the top, oldest sits at bit 0
  assign q_next = {din, q[DEPTH-1:1]};

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
      end
    end
  endgenerate
endmodule

// File: rtl/dts_fill_tracker.sv
module dts_fill_tracker #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic full_o
);
  import dts_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  fill_state_e   state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= FILLING;
    end else if (state_q == FILLING) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(DEPTH - 1)) state_q <= ARMED;
    end
  end

  assign full_o = (state_q == ARMED);
endmodule

// File: rtl/dts_edge_mapper.sv
module dts_edge_mapper #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0]   fall_q,
  input  logic [DEPTH-1:0]   rise_next,
  output logic [2*DEPTH-1:0] window_o,
  output logic [2*DEPTH-2:0] map_o
);
  localparam int WIN = 2 * DEPTH;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_merge
      assign window_o[2*k]   = fall_q[k];
      assign window_o[2*k+1] = rise_next[k];
    end
    for (genvar i = 0; i < WIN - 1; i++) begin : g_xor
      assign map_o[i] = window_o[i] ^ window_o[i+1];
    end
  endgenerate
endmodule

// File: rtl/dts_transition_sampler.sv
module dts_transition_sampler #(
  parameter int HALF_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      phi_i,
  input  logic                      probe_i,
  output logic [2*HALF_DEPTH-1:0]   snap_o,
  output logic [2*HALF_DEPTH-2:0]   edge_map_o,
  output logic                      valid_o
);
  localparam int WIN  = 2 * HALF_DEPTH;
  localparam int MAPW = WIN - 1;

  logic                  phi_rise;
  logic                  win_full;
  logic [HALF_DEPTH-1:0] rise_q, rise_next;
  logic [HALF_DEPTH-1:0] fall_q, fall_next;
  logic [WIN-1:0]        window;
  logic [MAPW-1:0]       map;
  logic                  take;

  dts_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .phase_i(phi_i), .rise_o(phi_rise)
  );

  dts_shift_bank #(.DEPTH(HALF_DEPTH), .ON_FALL(1'b0)) u_rise_bank (
    .clk(clk), .rst_n(rst_n), .din(probe_i), .q(rise_q), .q_next(rise_next)
  );

  dts_shift_bank #(.DEPTH(HALF_DEPTH), .ON_FALL(1'b1)) u_fall_bank (
    .clk(clk), .rst_n(rst_n), .din(probe_i), .q(fall_q), .q_next(fall_next)
  );

  dts_fill_tracker #(.DEPTH(HALF_DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .full_o(win_full)
  );

  dts_edge_mapper #(.DEPTH(HALF_DEPTH)) u_mapper (
    .fall_q(fall_q), .rise_next(rise_next), .window_o(window), .map_o(map)
  );

  assign take = phi_rise & win_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o     <= '0;
      edge_map_o <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= take;
      if (take) begin
        snap_o     <= window;
        edge_map_o <= map;
      end
    end
  end
endmodule

// File: rtl/dts_transition_sampler_chk.sv
module dts_transition_sampler_chk #(
  parameter int HALF_DEPTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid_o,
  input logic [2*HALF_DEPTH-1:0] snap_o,
  input logic [2*HALF_DEPTH-2:0] edge_map_o
);
  localparam int WIN = 2 * HALF_DEPTH;

  p_map_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (($countones(edge_map_o) % 2) == int'(snap_o[0] ^ snap_o[WIN-1])));

  p_flat_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (snap_o == '0 || snap_o == '1)) |-> (edge_map_o == '0));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(snap_o) && $stable(edge_map_o)));
endmodule

bind dts_transition_sampler dts_transition_sampler_chk #(.HALF_DEPTH(HALF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .snap_o(snap_o), .edge_map_o(edge_map_o)
);

// File: tb/dts_transition_sampler_tb.sv
module dts_transition_sampler_tb;
  localparam int N = 16;
  localparam int W = 2 * N;
  localparam int M = W - 1;
  localparam int HN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi = 1'b0;
  logic probe = 1'b0;
  logic [W-1:0] snap;
  logic [M-1:0] emap;
  logic valid;

  dts_transition_sampler #(.HALF_DEPTH(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .phi_i(phi), .probe_i(probe),
    .snap_o(snap), .edge_map_o(emap), .valid_o(valid)
  );

  always #10 clk = ~clk;

  bit hist [HN];
  int hc = 0, pc = 0, rel_pc = 0, exp_pc = 0;
  bit armed = 1'b0, done = 1'b0;
  int checks = 0, failures = 0;
  logic [W-1:0] exp_snap = '0;
  logic [M-1:0] exp_map = '0;

  function automatic logic [W-1:0] model_window();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = hist[(hc - 1 - (W - 1 - i)) % HN];
    return w;
  endfunction

  function automatic logic [M-1:0] model_map(logic [W-1:0] w);
    logic [M-1:0] m;
    for (int i = 0; i < M; i++) m[i] = w[i] ^ w[i+1];
    return m;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h at t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    hist[hc % HN] = probe;
    hc++;
    pc++;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 valid", 64'(valid), 64'd0);
      check("R1 snap", 64'(snap), 64'd0);
      check("R1 map", 64'(emap), 64'd0);
    end else if (armed && pc == exp_pc) begin
      armed = 1'b0;
      if (exp_pc - 1 - rel_pc >= N) begin
        exp_snap = model_window();
        exp_map  = model_map(exp_snap);
        check("R3/R6 strobe", 64'(valid), 64'd1);
        check("R2 window", 64'(snap), 64'(exp_snap));
        check("R4 map", 64'(emap), 64'(exp_map));
        if (exp_snap == '0 || exp_snap == '1) check("R5 flat map", 64'(emap), 64'd0);
      end else begin
        check("R8 early strobe", 64'(valid), 64'd0);
        check("R8 early snap", 64'(snap), 64'(exp_snap));
      end
    end else begin
      check("R6/R9 no strobe", 64'(valid), 64'd0);
      check("R7 hold snap", 64'(snap), 64'(exp_snap));
      check("R7 hold map", 64'(emap), 64'(exp_map));
    end
    hist[hc % HN] = probe;
    hc++;
  end

  task automatic half();
    @(clk);
    #5;
  endtask

  task automatic raise_phi();
    phi = 1'b1;
    armed = 1'b1;
    exp_pc = pc + 3;
  endtask

  // mode: 0 dense random, 1 low, 2 high, 3 one toggle, 4 sparse random
  task automatic drive_probe(int mode, int idx, int tog);
    case (mode)
      0: probe = 1'($urandom);
      1: probe = 1'b0;
      2: probe = 1'b1;
      3: if (idx == tog) probe = ~probe;
      default: if ($urandom_range(9) == 0) probe = ~probe;
    endcase
  endtask

  task automatic run_period(int hi, int lo, int mode);
    int tog = $urandom_range(hi + lo - 1);
    raise_phi();
    for (int i = 0; i < hi; i++) begin half(); drive_probe(mode, i, tog); end
    phi = 1'b0;
    for (int i = 0; i < lo; i++) begin half(); drive_probe(mode, hi + i, tog); end
  endtask

  task automatic do_reset();
    half();
    rst_n = 1'b0;
    phi = 1'b0;
    armed = 1'b0;
    exp_snap = '0;
    exp_map = '0;
    for (int i = 0; i < 4; i++) half();
    rst_n = 1'b1;
    rel_pc = pc;
  endtask

  // raise phi so the capture edge has exactly 'prior' rising edges since release
  task automatic boundary(int prior);
    do_reset();
    while (pc - rel_pc < prior - 2) half();
    raise_phi();
    for (int i = 0; i < 10; i++) half();
    phi = 1'b0;
    for (int i = 0; i < 10; i++) half();
  endtask

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 6; i++) half();
    rst_n = 1'b1;
    rel_pc = pc;
    // R8: rise right after reset release is ignored
    half();
    run_period(12, 12, 0);
    // R8 boundary: N-1 prior edges rejected, N accepted
    boundary(N - 1);
    boundary(N);
    // R5: long flat stretches, low then high
    run_period(20, 20, 1);
    run_period(20, 20, 1);
    run_period(20, 20, 2);
    run_period(20, 20, 2);
    // R2/R4: single toggles and dense patterns
    for (int k = 0; k < 6; k++) run_period(16, 16, 3);
    run_period(16, 16, 0);
    // R1: reset mid-run clears outputs
    do_reset();
    for (int k = 0; k < 200; k++)
      run_period($urandom_range(6, 30), $urandom_range(6, 30), $urandom_range(4));
    for (int i = 0; i < 10; i++) half();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule